// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This combinational block prepares the second operand of an integer ALU. It takes a 32-bit value and moves it by a selected amount in one of several ways: a shift left, a logical or arithmetic shift right, a rotate right, or a one-bit rotate through the carry flag. Next to the moved value it produces a carry-out, which a logical operation can write to the carry flag.

The shift amount comes from a 6-bit constant field or from a register operand. For a register operand only the low 8 bits are used, so amounts from 0 to 255 are possible. Every type and every amount has a defined result and carry-out. When the amount is zero, the value and the incoming carry pass through unchanged. Amounts beyond the word width saturate in a defined way. The block has no clock and no state, and the instruction decoder that drives its select inputs sits outside it.

Top module: `opnd_shifter`

## Requirements
- R1: Kind codes 000 and 101 both shift left and fill with zeros. For an amount n from 1 to 32 the carry-out is din[32-n]. For n above 32 the result is 0 and the carry-out is 0.
- R2: Kind code 001 shifts right and fills with zeros. For n from 1 to 32 the carry-out is din[n-1]. For n above 32 the result is 0 and the carry-out is 0.
- R3: Kind code 010 shifts right and fills with copies of din[31]. For n from 1 to 31 the carry-out is din[n-1]. For n of 32 or more, every result bit and the carry-out equal din[31].
- R4: Kind code 011 rotates right by n mod 32, and the carry-out is result bit 31. When n is a nonzero multiple of 32, the value is unchanged and the carry-out is din[31].
- R5: Kind code 100 moves the value right by one, puts cin into bit 31 and gives din[0] as the carry-out. The amount inputs have no effect on this code.
- R6: For every kind code other than 100, an amount of zero gives dout = din and cout = cin.
- R7: When amt_from_reg is 1, the amount is reg_amt[7:0] and bits 31:8 of reg_amt are ignored. When amt_from_reg is 0, the amount is imm_amt, taken without sign (0 to 63).
- R8: Kind codes 110 and 111 pass din and cin through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din | input | 32 | Value to be moved |
| sh_kind | input | 3 | Shift kind code (see R1 to R8) |
| imm_amt | input | 6 | Constant amount field |
| reg_amt | input | 32 | Register operand that holds the amount in its low 8 bits |
| amt_from_reg | input | 1 | 1 takes the amount from reg_amt, 0 takes it from imm_amt |
| cin | input | 1 | Current carry flag |
| dout | output | 32 | Moved value |
| cout | output | 1 | Shifter carry-out |

## Verification
Directed cases cover the amounts 0, 1, 31, 32, 33, 64 and 255 for every kind code. These cases tell apart the zero pass-through, the last-bit carry, the exact-width case and the saturated case. Each of them is tried with a negative and a positive value, which tells sign fill apart from zero fill. Rotates by 32 and 64 tell a wrapped amount apart from a plain zero amount. Random values, kinds, amounts and carries with a fixed seed then catch mistakes in bit order and carry selection. Each random case drives a register operand with junk in its upper bits, to show that those bits do not matter.

// File: rtl/opnd_shifter.sv
module opnd_shifter #(
  parameter int W      = 32,
  parameter int IMM_W  = 6,
  parameter int RAMT_W = 8
) (
  input  logic [W-1:0]     din,
  input  logic [2:0]       sh_kind,
  input  logic [IMM_W-1:0] imm_amt,
  input  logic [W-1:0]     reg_amt,
  input  logic             amt_from_reg,
  input  logic             cin,
  output logic [W-1:0]     dout,
  output logic             cout
);
  localparam int RW = $clog2(W);

  logic [RAMT_W-1:0] n;
  logic [2*W-1:0]    lsl_x, lsr_x, asr_x, ror_x;
  logic              zero_n;
  logic              unused_bits;

  assign n      = amt_from_reg ? reg_amt[RAMT_W-1:0] : RAMT_W'(imm_amt);
  assign zero_n = (n == '0);

  assign lsl_x = {{W{1'b0}}, din} << n;
  assign lsr_x = {din, {W{1'b0}}} >> n;
  assign asr_x = $signed({din, {W{1'b0}}}) >>> n;
  assign ror_x = {din, din} >> n[RW-1:0];

  assign unused_bits = ^{reg_amt[W-1:RAMT_W], lsl_x[2*W-1:W+1],
                         lsr_x[W-2:0], asr_x[W-2:0], ror_x[2*W-1:W]};

  always_comb begin
    dout = din;
    cout = cin;
    case (sh_kind)
      3'b000, 3'b101:
        if (!zero_n) begin
          dout = lsl_x[W-1:0];
          cout = lsl_x[W];
        end
      3'b001:
        if (!zero_n) begin
          dout = lsr_x[2*W-1:W];
          cout = lsr_x[W-1];
        end
      3'b010:
        if (!zero_n) begin
          dout = asr_x[2*W-1:W];
          cout = asr_x[W-1];
        end
      3'b011:
        if (!zero_n) begin
          dout = ror_x[W-1:0];
          cout = ror_x[W-1];
        end
      3'b100: begin
        dout = {cin, din[W-1:1]};
        cout = din[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk #(
  parameter int W      = 32,
  parameter int IMM_W  = 6,
  parameter int RAMT_W = 8
) (
  input logic [W-1:0]     din,
  input logic [2:0]       sh_kind,
  input logic [IMM_W-1:0] imm_amt,
  input logic [W-1:0]     reg_amt,
  input logic             amt_from_reg,
  input logic             cin,
  input logic [W-1:0]     dout,
  input logic             cout
);
  logic [RAMT_W-1:0] amt;
  assign amt = amt_from_reg ? reg_amt[RAMT_W-1:0] : RAMT_W'(imm_amt);

  always_comb begin
    if (sh_kind != 3'b100 && amt == '0)
      a_r6_zero_amount_passes: assert (dout == din && cout == cin);
    if (sh_kind[2:1] == 2'b11)
      a_r8_spare_codes_pass: assert (dout == din && cout == cin);
    if (sh_kind == 3'b100)
      a_r5_rrx_keeps_bits: assert ($countones({cin, din}) == $countones({dout, cout}));
    if (sh_kind == 3'b011)
      a_r4_rotate_keeps_bits: assert ($countones(dout) == $countones(din));
    if (sh_kind == 3'b010)
      a_r3_sign_kept: assert (dout[W-1] == din[W-1]);
    if (sh_kind == 3'b001 && amt > RAMT_W'(W))
      a_r2_lsr_flushed: assert (dout == '0 && !cout);
    if ((sh_kind == 3'b000 || sh_kind == 3'b101) && amt > RAMT_W'(W))
      a_r1_lsl_flushed: assert (dout == '0 && !cout);
  end
endmodule

bind opnd_shifter opnd_shifter_chk #(.W(W), .IMM_W(IMM_W), .RAMT_W(RAMT_W)) chk (.*);

// File: tb/opnd_shifter_test.sv
`timescale 1ns/100ps
module opnd_shifter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] din, reg_amt, dout;
  logic [2:0]  sh_kind;
  logic [5:0]  imm_amt;
  logic        amt_from_reg, cin, cout;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  opnd_shifter uut (.din(din), .sh_kind(sh_kind), .imm_amt(imm_amt), .reg_amt(reg_amt),
                    .amt_from_reg(amt_from_reg), .cin(cin), .dout(dout), .cout(cout));

  function automatic string tag_of(input logic [2:0] k, input int n);
    if (k[2:1] == 2'b11) return "R8";
    if (n == 0 && k != 3'b100) return "R6";
    case (k)
      3'b000, 3'b101: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      default: return "R5";
    endcase
  endfunction

  // one position per step; carry is the bit that leaves
  function automatic logic [32:0] model(input logic [31:0] v, input logic [2:0] k,
                                        input int n, input logic c);
    logic [31:0] x = v;
    logic cy = c;
    if (k == 3'b100) return {v[0], c, v[31:1]};
    if (k[2:1] == 2'b11) return {c, v};
    for (int i = 0; i < n; i++) begin
      case (k)
        3'b001: begin cy = x[0];  x = {1'b0, x[31:1]}; end
        3'b010: begin cy = x[0];  x = {x[31], x[31:1]}; end
        3'b011: begin cy = x[0];  x = {x[0], x[31:1]}; end
        default: begin cy = x[31]; x = {x[30:0], 1'b0}; end
      endcase
    end
    return {cy, x};
  endfunction

  task automatic run(input logic [31:0] v, input logic [2:0] k, input int n, input logic c,
                     input bit use_reg, input logic [23:0] junk, input string tag);
    logic [32:0] exp;
    @(posedge clk);
    din = v; sh_kind = k; cin = c; amt_from_reg = use_reg;
    if (use_reg) begin
      reg_amt = {junk, 8'(n)}; imm_amt = 6'($urandom);
    end else begin
      imm_amt = 6'(n); reg_amt = $urandom;
    end
    @(negedge clk);
    exp = model(v, k, n, c);
    checks++;
    if ({cout, dout} !== exp) begin
      errors++;
      $display("FAIL %s kind=%b n=%0d din=%h cin=%b: got dout=%h cout=%b exp dout=%h cout=%b",
               tag, k, n, v, c, dout, cout, exp[31:0], exp[32]);
    end
  endtask

  initial begin
    int amts[7] = '{0, 1, 31, 32, 33, 64, 255};
    logic [31:0] vals[2] = '{32'h8000_0001, 32'h6A5C_3E97};
    void'($urandom(32'd20240917));
    din = '0; sh_kind = '0; imm_amt = '0; reg_amt = '0; amt_from_reg = 1'b0; cin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (dout !== 32'h0 || cout !== 1'b0) begin
      errors++;
      $display("FAIL R6 reset idle: got dout=%h cout=%b exp dout=0 cout=0", dout, cout);
    end
    rst = 1'b0;
    for (int k = 0; k < 8; k++)
      for (int a = 0; a < 7; a++)
        for (int v = 0; v < 2; v++)
          run(vals[v], 3'(k), amts[a], v[0], 1'b1, 24'hDEAD5B,
              tag_of(3'(k), amts[a]));
    run(32'hF000_000F, 3'b011, 32, 1'b0, 1'b1, 24'h0, "R4");
    run(32'h7000_000E, 3'b011, 64, 1'b1, 1'b1, 24'h0, "R4");
    run(32'h1234_5679, 3'b100, 17, 1'b1, 1'b0, 24'h0, "R5");
    run(32'h1234_5679, 3'b100, 200, 1'b0, 1'b1, 24'hFFFFFF, "R5");
    run(32'h8000_0000, 3'b010, 63, 1'b0, 1'b0, 24'h0, "R7");
    run(32'h0000_0100, 3'b000, 8, 1'b0, 1'b1, 24'hFFFFFF, "R7");
    run(32'hCAFE_F00D, 3'b001, 0, 1'b1, 1'b1, 24'hFFFF00, "R7");
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] k = 3'($urandom);
      bit ur = 1'($urandom);
      int n = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 34);
      if (!ur) n = n % 64;
      run($urandom, k, n, 1'($urandom), ur, 24'($urandom),
          ur ? {tag_of(k, n), "/R7"} : tag_of(k, n));
    end
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done || cycles > 100000) begin
      if (!done) begin
        errors++;
        $display("FAIL watchdog: got %0d cycles exp completion", cycles);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule